// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block drives the external memory bus of an 8-bit controller core. A machine cycle lasts twelve clock periods, read as six states of two phases, and splits into two six-period slots. In a slot the block pulses the address-latch strobe while it drives the low address byte on a shared address/data port. It then either pulses the program-store read strobe for a code byte, or, in an external data cycle, holds a six-period read or write strobe. The high address byte is driven on a separate port.

The core makes one request per machine cycle through plain level inputs: a code-fetch enable with its address, and a data or code-table request with its address, direction, address width and write data. The block samples the request in the last period of each machine cycle, which it flags on `mc_last`. The byte captured from the shared port is returned on `cap_data` with a one-clock valid pulse. A software-held control bit can silence the address-latch strobe in machine cycles that do no external access. That bit has no effect while the core executes from external memory.

Top module: `mbs_bus_seq`

## Requirements
- R1: The machine cycle is 12 clocks long. `mc_last` is high in the last clock of each cycle (phase 11) and only there, and the request inputs are sampled at the clock edge that ends phase 11.
- R2: With the address-latch strobe enabled, `ale` is high in phases 0-1 and 6-7 of every machine cycle. That is one pulse every 6 clocks, each 2 clocks wide.
- R3: A code cycle (`fetch_en`) fetches `fetch_addr` in slot 0 and `fetch_addr+1` in slot 1. `psen_n` is low in phases 3-5 and 9-11. The address low byte is driven (`ad_oe`=1) in phases 0-2 and 6-8, and the port floats in the other phases.
- R4: In a program read, `ad_in` is captured at the clock edge where `psen_n` rises. `cap_data` then shows that byte, with `cap_vld`=1 and `cap_dx`=0 for code, in the following clock: phase 6, or phase 0 of the next cycle.
- R5: A data cycle (`dx_req`) pulses `ale` only in phases 0-1, keeps `psen_n` high for the whole cycle, and holds `rd_n` (read, `dx_write`=0) or `wr_n` (write, `dx_write`=1) low in phases 4-9.
- R6: For a data read, `ad_in` is captured at the edge where `rd_n` rises. It appears on `cap_data` with `cap_vld`=1 and `cap_dx`=1 in phase 10.
- R7: For a data write, `ad_out` carries the address low byte in phases 0-2 and `dx_wdata` in phases 3-10, so the data is still driven one clock after `wr_n` rises. `ad_oe` is high in phases 0-10 and low in phase 11.
- R8: `a_hi` is the high byte of the slot address in code cycles, in table slot 0 and in data cycles with `dx_wide`=1. In data cycles with `dx_wide`=0, in idle cycles and in table slot 1 it follows `p2_reg`.
- R9: In a cycle with no request (idle), `ale_off`=1 with `ext_mode`=0 keeps `ale` low for the whole cycle. The port is not driven in any idle cycle.
- R10: `ext_mode`=1 overrides `ale_off`: idle cycles pulse `ale` as in R2.
- R11: A table cycle (`tb_req`) reads the full 16-bit `dx_addr` in slot 0, with `psen_n` low in phases 3-5, and returns the byte with `cap_dx`=1 in phase 6. Slot 1 has no program read. `ale` pulses in both slots even when `ale_off`=1.
- R12: When several requests are present, a data request wins over a table request, and a table request wins over a code fetch.
- R13: During reset, `ale`, `ad_oe` and `cap_vld` are 0, `psen_n`, `rd_n` and `wr_n` are 1, and `mc_last` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Core executes from external program memory |
| ale_off | input | 1 | Software bit silencing the address-latch strobe in idle cycles |
| fetch_en | input | 1 | Request a two-byte code fetch cycle |
| fetch_addr | input | 16 | Code address of slot 0 |
| dx_req | input | 1 | Request an external data cycle |
| dx_write | input | 1 | Data direction, 1 = write |
| dx_wide | input | 1 | Data address is 16 bits (1) or 8 bits (0) |
| dx_addr | input | 16 | Data or code-table address |
| dx_wdata | input | 8 | Write data |
| tb_req | input | 1 | Request a code-table read cycle |
| p2_reg | input | 8 | High port register value |
| ad_in | input | 8 | Byte read from the shared port |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared port output byte |
| ad_oe | output | 1 | Shared port drive enable |
| a_hi | output | 8 | High address port |
| mc_last | output | 1 | Last clock of the machine cycle |
| cap_data | output | 8 | Captured read byte |
| cap_vld | output | 1 | One-clock pulse: `cap_data` is new |
| cap_dx | output | 1 | Captured byte came from a data or table read |

## Verification
Every bus pin is a flop loaded from the next-phase decode, so its value for phase k is due in the clock that follows the k-th edge after the sampling edge. The bench sets a request in the phase-11 clock and then reads all pins at the falling edge of each of the next twelve clocks, comparing each against the phase-indexed pattern. Captured bytes come one clock after the strobe edge that takes them. The bench changes `ad_in` to a phase-unique value after each comparison, so a capture taken one clock early or late shows up as a wrong byte, in phase 6, phase 10 or phase 0 of the next cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int MB_AW = 16;
  localparam int MB_DW = 8;

  typedef enum logic [1:0] {
    CY_IDLE  = 2'd0,
    CY_CODE  = 2'd1,
    CY_DATA  = 2'd2,
    CY_TABLE = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e            kind;
    logic                 write;
    logic                 wide;
    logic [MB_AW-1:0]     faddr;
    logic [MB_AW-1:0]     daddr;
    logic [MB_DW-1:0]     wdata;
  } bus_req_t;

  typedef struct packed {
    logic                 ale;
    logic                 psen_n;
    logic                 rd_n;
    logic                 wr_n;
    logic                 oe;
    logic [MB_DW-1:0]     lo;
    logic [MB_DW-1:0]     hi;
    logic                 last;
  } bus_pins_t;
endpackage

// File: rtl/mbs_phase_ctr.sv
module mbs_phase_ctr #(
  parameter int CYC = 12,
  localparam int PW = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph,
  output logic [PW-1:0] ph_n,
  output logic          wrap
);
  assign wrap = (ph == PW'(CYC-1));
  assign ph_n = wrap ? '0 : ph + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) ph <= PW'(CYC-1);
    else     ph <= ph_n;
  end
endmodule

// File: rtl/mbs_req_latch.sv
module mbs_req_latch
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              fetch_en,
  input  logic [MB_AW-1:0]  fetch_addr,
  input  logic              dx_req,
  input  logic              dx_write,
  input  logic              dx_wide,
  input  logic [MB_AW-1:0]  dx_addr,
  input  logic [MB_DW-1:0]  dx_wdata,
  input  logic              tb_req,
  output bus_req_t          nxt,
  output cyc_kind_e         cur_kind,
  output logic              cur_write
);
  bus_req_t cur;
  bus_req_t sel;

  always_comb begin
    sel.kind  = dx_req   ? CY_DATA  :
                tb_req   ? CY_TABLE :
                fetch_en ? CY_CODE  : CY_IDLE;
    sel.write = dx_write;
    sel.wide  = dx_wide;
    sel.faddr = fetch_addr;
    sel.daddr = dx_addr;
    sel.wdata = dx_wdata;
    nxt       = take ? sel : cur;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign cur_kind  = cur.kind;
  assign cur_write = cur.write;
endmodule

// File: rtl/mbs_strobe_dec.sv
module mbs_strobe_dec
  import mbs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int CYC    = STATES * PHASES,
  localparam int PW     = $clog2(CYC),
  localparam int SLOT   = CYC / 2,
  localparam int ALE_W  = PHASES,
  localparam int PS_BEG = ALE_W + 1,
  localparam int RD_BEG = 2 * PHASES,
  localparam int RD_END = RD_BEG + 3 * PHASES - 1,
  localparam int WD_END = RD_END + 1
) (
  input  logic [PW-1:0]    ph,
  input  bus_req_t         req,
  input  logic             ale_off,
  input  logic             ext_mode,
  input  logic [MB_DW-1:0] p2_reg,
  output bus_pins_t        pins
);
  logic             slot;
  logic [PW-1:0]    pos;
  logic             ale_en, live, adr_ph, is_rd, is_wr, strobe_win;
  logic [MB_AW-1:0] caddr;

  assign slot   = (ph >= PW'(SLOT));
  assign pos    = slot ? ph - PW'(SLOT) : ph;
  assign ale_en = !ale_off || ext_mode || (req.kind != CY_IDLE);
  assign live   = (req.kind == CY_CODE) ||
                  (((req.kind == CY_DATA) || (req.kind == CY_TABLE)) && !slot);
  assign caddr  = (req.kind == CY_CODE) ? req.faddr + MB_AW'(slot) : req.daddr;
  assign adr_ph = live && (pos < PW'(PS_BEG));
  assign is_rd  = (req.kind == CY_DATA) && !req.write;
  assign is_wr  = (req.kind == CY_DATA) &&  req.write;
  assign strobe_win = (ph >= PW'(RD_BEG)) && (ph <= PW'(RD_END));

  always_comb begin
    pins.ale    = ale_en && (pos < PW'(ALE_W)) && !((req.kind == CY_DATA) && slot);
    pins.psen_n = !(((req.kind == CY_CODE) || ((req.kind == CY_TABLE) && !slot))
                    && (pos >= PW'(PS_BEG)));
    pins.rd_n   = !(is_rd && strobe_win);
    pins.wr_n   = !(is_wr && strobe_win);
    pins.oe     = adr_ph || (is_wr && (ph >= PW'(PS_BEG)) && (ph <= PW'(WD_END)));
    pins.lo     = adr_ph ? caddr[MB_DW-1:0] : req.wdata;
    if ((req.kind == CY_CODE) || ((req.kind == CY_TABLE) && !slot) ||
        ((req.kind == CY_DATA) && req.wide))
      pins.hi = caddr[MB_AW-1:MB_DW];
    else
      pins.hi = p2_reg;
    pins.last   = (ph == PW'(CYC-1));
  end
endmodule

// File: rtl/mbs_bus_seq.sv
module mbs_bus_seq
  import mbs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic             ale_off,
  input  logic             fetch_en,
  input  logic [15:0]      fetch_addr,
  input  logic             dx_req,
  input  logic             dx_write,
  input  logic             dx_wide,
  input  logic [15:0]      dx_addr,
  input  logic [7:0]       dx_wdata,
  input  logic             tb_req,
  input  logic [7:0]       p2_reg,
  input  logic [7:0]       ad_in,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [7:0]       ad_out,
  output logic             ad_oe,
  output logic [7:0]       a_hi,
  output logic             mc_last,
  output logic [7:0]       cap_data,
  output logic             cap_vld,
  output logic             cap_dx
);
  localparam int CYC    = STATES * PHASES;
  localparam int PW     = $clog2(CYC);
  localparam int SLOT   = CYC / 2;
  localparam int RD_END = 2 * PHASES + 3 * PHASES - 1;

  logic [PW-1:0] ph, ph_n;
  logic          wrap;
  bus_req_t      req_n;
  cyc_kind_e     cur_kind;
  logic          cur_write;
  bus_pins_t     pins_n, pins_q;
  logic          code_end, rd_end;

  mbs_phase_ctr #(.CYC(CYC)) ctr_i (
    .clk(clk), .rst(rst), .ph(ph), .ph_n(ph_n), .wrap(wrap)
  );

  mbs_req_latch req_i (
    .clk(clk), .rst(rst), .take(wrap),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .dx_req(dx_req), .dx_write(dx_write), .dx_wide(dx_wide),
    .dx_addr(dx_addr), .dx_wdata(dx_wdata), .tb_req(tb_req),
    .nxt(req_n), .cur_kind(cur_kind), .cur_write(cur_write)
  );

  mbs_strobe_dec #(.STATES(STATES), .PHASES(PHASES)) dec_i (
    .ph(ph_n), .req(req_n), .ale_off(ale_off), .ext_mode(ext_mode),
    .p2_reg(p2_reg), .pins(pins_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0,
                  lo: '0, hi: '0, last: 1'b1};
    end else begin
      pins_q <= pins_n;
    end
  end

  // program read ends where the strobe rises; data read ends with the read strobe
  assign code_end = ((cur_kind == CY_CODE) && ((ph == PW'(SLOT-1)) || (ph == PW'(CYC-1)))) ||
                    ((cur_kind == CY_TABLE) && (ph == PW'(SLOT-1)));
  assign rd_end   = (cur_kind == CY_DATA) && !cur_write && (ph == PW'(RD_END));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      cap_vld  <= 1'b0;
      cap_dx   <= 1'b0;
    end else begin
      cap_vld <= code_end || rd_end;
      if (code_end || rd_end) begin
        cap_data <= ad_in;
        cap_dx   <= (cur_kind != CY_CODE);
      end
    end
  end

  assign ale     = pins_q.ale;
  assign psen_n  = pins_q.psen_n;
  assign rd_n    = pins_q.rd_n;
  assign wr_n    = pins_q.wr_n;
  assign ad_oe   = pins_q.oe;
  assign ad_out  = pins_q.lo;
  assign a_hi    = pins_q.hi;
  assign mc_last = pins_q.last;
endmodule

// File: rtl/mbs_bus_chk.sv
module mbs_bus_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic mc_last,
  input logic cap_vld
);
  a_r1_last_single: assert property (@(posedge clk) disable iff (rst)
    mc_last |=> !mc_last);

  a_r2_ale_two_wide: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (ale ##1 !ale));

  a_r5_no_fetch_in_data: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (rd_n && wr_n));

  a_r5_no_ale_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ale);

  a_r4_cap_on_psen_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> cap_vld);

  a_r6_cap_on_rd_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> cap_vld);

  a_r7_wdata_held: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> ad_oe);
endmodule

bind mbs_bus_seq mbs_bus_chk chk_i (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .mc_last(mc_last), .cap_vld(cap_vld)
);

// File: tb/mbs_bus_seq_tb.sv
module mbs_bus_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_mode = 0, ale_off = 0, fetch_en = 0, dx_req = 0, dx_write = 0;
  logic dx_wide = 0, tb_req = 0;
  logic [15:0] fetch_addr = '0, dx_addr = '0;
  logic [7:0]  dx_wdata = '0, p2_reg = '0, ad_in = '0;
  logic ale, psen_n, rd_n, wr_n, ad_oe, mc_last, cap_vld, cap_dx;
  logic [7:0] ad_out, a_hi, cap_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbs_bus_seq dut_i (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .ale_off(ale_off),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr), .dx_req(dx_req),
    .dx_write(dx_write), .dx_wide(dx_wide), .dx_addr(dx_addr),
    .dx_wdata(dx_wdata), .tb_req(tb_req), .p2_reg(p2_reg), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .mc_last(mc_last), .cap_data(cap_data),
    .cap_vld(cap_vld), .cap_dx(cap_dx)
  );

  task automatic chk(string tag, string what, int k, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s phase %0d: actual %0h expected %0h", tag, what, k, act, exp);
    end
  endtask

  task automatic clear_req();
    fetch_en = 0; dx_req = 0; tb_req = 0; dx_write = 0; dx_wide = 0;
  endtask

  // kind: 0 idle, 1 code, 2 data, 3 table; run one machine cycle and check every phase
  task automatic run_cycle(int kind, string atag);
    bit wr = dx_write;
    bit ale_en = !ale_off || ext_mode || (kind != 0);
    while (!mc_last) @(negedge clk);
    ad_in = 8'h9F;
    for (int k = 0; k < 12; k++) begin
      bit slot = (k >= 6);
      int p = k % 6;
      bit live = (kind == 1) || (((kind == 2) || (kind == 3)) && !slot);
      logic [15:0] adr = (kind == 1) ? fetch_addr + 16'(slot) : dx_addr;
      bit e_oe = (live && p < 3) || (kind == 2 && wr && k >= 3 && k <= 10);
      logic [7:0] e_hi;
      @(negedge clk);
      if (kind == 1 || (kind == 3 && !slot) || (kind == 2 && dx_wide)) e_hi = adr[15:8];
      else e_hi = p2_reg;
      chk(atag, "ale", k, int'(ale), int'(ale_en && p < 2 && !(kind == 2 && slot)));
      chk("R3", "psen_n", k, int'(psen_n),
          int'(!((kind == 1 || (kind == 3 && !slot)) && p >= 3)));
      chk("R5", "rd_n", k, int'(rd_n), int'(!(kind == 2 && !wr && k >= 4 && k <= 9)));
      chk("R5", "wr_n", k, int'(wr_n), int'(!(kind == 2 && wr && k >= 4 && k <= 9)));
      chk("R7", "ad_oe", k, int'(ad_oe), int'(e_oe));
      if (e_oe)
        chk("R7", "ad_out", k, int'(ad_out), (live && p < 3) ? int'(adr[7:0]) : int'(dx_wdata));
      chk("R8", "a_hi", k, int'(a_hi), int'(e_hi));
      chk("R1", "mc_last", k, int'(mc_last), int'(k == 11));
      if (k == 6 && (kind == 1 || kind == 3)) begin
        chk("R4", "cap_vld", k, int'(cap_vld), 1);
        chk("R4", "cap_data", k, int'(cap_data), 'hA5);
        chk("R11", "cap_dx", k, int'(cap_dx), int'(kind == 3));
      end else if (k == 10 && kind == 2 && !wr) begin
        chk("R6", "cap_vld", k, int'(cap_vld), 1);
        chk("R6", "cap_data", k, int'(cap_data), 'hA9);
        chk("R6", "cap_dx", k, int'(cap_dx), 1);
      end else if (k != 0) begin
        chk("R4", "cap_vld", k, int'(cap_vld), 0);
      end
      ad_in = 8'hA0 + 8'(k);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R13", "ale", 0, int'(ale), 0);
    chk("R13", "psen_n", 0, int'(psen_n), 1);
    chk("R13", "rd_n", 0, int'(rd_n), 1);
    chk("R13", "wr_n", 0, int'(wr_n), 1);
    chk("R13", "ad_oe", 0, int'(ad_oe), 0);
    chk("R13", "cap_vld", 0, int'(cap_vld), 0);
    chk("R13", "mc_last", 0, int'(mc_last), 1);
    rst = 0;
  endtask

  task automatic t_idle_ale_runs();
    clear_req(); ale_off = 0; ext_mode = 0; p2_reg = 8'h3C;
    run_cycle(0, "R2");
  endtask

  task automatic t_code_fetch();
    clear_req(); fetch_en = 1; fetch_addr = 16'h12FF;
    run_cycle(1, "R2");
    @(negedge clk);
    chk("R4", "cap_vld slot1", 0, int'(cap_vld), 1);
    chk("R4", "cap_data slot1", 0, int'(cap_data), 'hAB);
    chk("R4", "cap_dx slot1", 0, int'(cap_dx), 0);
  endtask

  task automatic t_data_read_priority();
    clear_req(); fetch_en = 1; tb_req = 1; dx_req = 1; dx_write = 0; dx_wide = 1;
    dx_addr = 16'hBEEF;
    run_cycle(2, "R12");
  endtask

  task automatic t_data_write_narrow();
    clear_req(); dx_req = 1; dx_write = 1; dx_wide = 0; dx_addr = 16'h0042;
    dx_wdata = 8'hC3; p2_reg = 8'h5A;
    run_cycle(2, "R7");
  endtask

  task automatic t_idle_ale_off();
    clear_req(); ale_off = 1; ext_mode = 0;
    run_cycle(0, "R9");
  endtask

  task automatic t_ext_override();
    clear_req(); ale_off = 1; ext_mode = 1;
    run_cycle(0, "R10");
  endtask

  task automatic t_table_read();
    clear_req(); ale_off = 1; ext_mode = 0; tb_req = 1; fetch_en = 1;
    dx_addr = 16'h7E21; p2_reg = 8'h99;
    run_cycle(3, "R11");
  endtask

  task automatic t_data_ale_off();
    clear_req(); ale_off = 1; dx_req = 1; dx_write = 0; dx_wide = 0; dx_addr = 16'h0010;
    run_cycle(2, "R9");
  endtask

  initial begin
    t_reset();
    t_idle_ale_runs();
    t_code_fetch();
    t_data_read_priority();
    t_data_write_narrow();
    t_idle_ale_off();
    t_ext_override();
    t_table_read();
    t_data_ale_off();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule